// File: doc/BRIEF.md
# Desaturation Blanking and Soft-Shutdown Sequencer

This block guards one power switch of a half bridge. It takes the channel's on/off command and a desaturation comparator output that is already synchronised to the system clock. From these it decides which gate stage to enable: the main source stage, a short boost source stage used at turn-on, the sink stage, or a weak soft-shutdown pull-down. A desaturation report counts only while the channel is on and after a blanking window that follows each turn-on. The report must also persist for a minimum number of consecutive cycles. Once a report qualifies, the block turns the switch off slowly. Both main stages are left in high impedance while only the pull-down is enabled, for a fixed number of cycles.

All durations are parameters counted in clock cycles; the defaults suit a 100 MHz clock (3 µs blanking, 1 µs filter, 9.6 µs soft shutdown, 200 ns boost). During the soft shutdown, an active-low busy flag is low. When it ends, a one-cycle done pulse is produced so that a fault latch outside this block can be set. The block then rests in the normal off state and turns on again only after a fresh off-to-on edge of the command. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `dsb_sequencer`

## Requirements
- R1: While reset is held and right after it, sink_en=1 and src_en=0, boost_en=0, ssd_en=0, ssd_busy_n=1, ssd_done=0.
- R2: From the off state, the clock edge that samples cmd_on=1 (after cmd_on=0 on the previous edge, or as the first sample after reset) turns the channel on: src_en=1 and sink_en=0 from the next cycle. In the on state, an edge that samples cmd_on=0 returns the outputs to the off state of R1 in the next cycle.
- R3: boost_en is 1 for exactly BOOST_CYC cycles, beginning with the first on cycle, and only while src_en=1.
- R4: desat_in is ignored on the edges that fall in the first BLANK_CYC on cycles after each turn-on.
- R5: Soft shutdown starts only after FILT_CYC consecutive edges sample desat_in=1 while unblanked and on. A shorter run has no effect and restarts the count.
- R6: desat_in has no effect while the channel is off.
- R7: For exactly SSD_CYC cycles, beginning in the cycle after the qualifying edge: ssd_en=1, ssd_busy_n=0, and src_en=sink_en=boost_en=0.
- R8: ssd_done is 1 for exactly one cycle: the first cycle after the soft shutdown, in which the outputs are back in the off state.
- R9: A soft shutdown runs to its end even if cmd_on falls. Afterwards the channel stays off until cmd_on has been sampled 0 and then 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Channel on command, synchronous |
| desat_in | input | 1 | Synchronised desaturation comparator output |
| src_en | output | 1 | Main source stage enable |
| boost_en | output | 1 | Turn-on boost source stage enable |
| sink_en | output | 1 | Sink stage enable |
| ssd_en | output | 1 | Soft-shutdown pull-down enable |
| ssd_busy_n | output | 1 | Low while soft shutdown is in progress |
| ssd_done | output | 1 | One-cycle pulse when soft shutdown completes |

## Verification
The directed runs each isolate one filter condition:
- A desaturation level held across the whole blanking window tells blanking apart from filtering.
- A run one cycle shorter than the filter length, followed by a full-length run, shows the exact qualification threshold.
- Desaturation while the channel is off shows it has no effect when off.
- Dropping the command in mid-shutdown, and holding it high through the end, tells completion apart from re-arming on a fresh edge.

Random command toggling mixed with random desaturation bursts of one to eight cycles then exercises every state transition against a cycle-exact reference model.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_ON   = 2'd1,
    CH_SOFT = 2'd2
  } ch_state_e;
endpackage

// File: rtl/dsb_timer.sv
module dsb_timer #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic idle,
  output logic last
);
  localparam int W = $clog2(TICKS + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= W'(TICKS);
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
  assign last = (cnt_q == W'(1));

  AST_TMR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !load) |=> idle); // R3
endmodule

// File: rtl/dsb_filter.sv
module dsb_filter #(
  parameter int MIN_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic hit
);
  localparam int W = $clog2(MIN_RUN + 1);
  localparam logic [W-1:0] TOP = W'(MIN_RUN - 1);

  logic [W-1:0] run_q;
  logic         live;

  assign live = en && din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!live)
      run_q <= '0;
    else if (run_q != TOP)
      run_q <= run_q + 1'b1;
  end

  assign hit = live && (run_q == TOP);

  AST_FILT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (run_q == '0)); // R5
endmodule

// File: rtl/dsb_sequencer.sv
module dsb_sequencer
  import dsb_pkg::*;
#(
  parameter int BLANK_CYC = 300,
  parameter int FILT_CYC  = 100,
  parameter int SSD_CYC   = 960,
  parameter int BOOST_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic desat_in,
  output logic src_en,
  output logic boost_en,
  output logic sink_en,
  output logic ssd_en,
  output logic ssd_busy_n,
  output logic ssd_done
);
  ch_state_e state_q, state_d;
  logic      cmd_q;
  logic      cmd_rise;
  logic      turn_on;
  logic      blank_idle, blank_last;
  logic      boost_live;
  logic      trip;
  logic      ssd_idle, ssd_last;
  logic      enter_soft;
  logic      done_q;

  assign cmd_rise   = cmd_on && !cmd_q;
  assign turn_on    = (state_q == CH_OFF) && cmd_rise;
  assign enter_soft = (state_q == CH_ON) && cmd_on && trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= 1'b0;
    else        cmd_q <= cmd_on;
  end

  dsb_timer #(.TICKS(BLANK_CYC)) u_blank (
    .clk (clk), .rst_n (rst_n),
    .load (turn_on), .run (state_q == CH_ON),
    .idle (blank_idle), .last (blank_last)
  );

  generate
    if (BOOST_CYC > 0) begin : g_boost
      logic b_idle, b_last;
      dsb_timer #(.TICKS(BOOST_CYC)) u_boost (
        .clk (clk), .rst_n (rst_n),
        .load (turn_on), .run (state_q == CH_ON),
        .idle (b_idle), .last (b_last)
      );
      assign boost_live = !b_idle;
    end else begin : g_noboost
      assign boost_live = 1'b0;
    end
  endgenerate

  dsb_filter #(.MIN_RUN(FILT_CYC)) u_filt (
    .clk (clk), .rst_n (rst_n),
    .en  ((state_q == CH_ON) && blank_idle),
    .din (desat_in),
    .hit (trip)
  );

  dsb_timer #(.TICKS(SSD_CYC)) u_soft (
    .clk (clk), .rst_n (rst_n),
    .load (enter_soft), .run (state_q == CH_SOFT),
    .idle (ssd_idle), .last (ssd_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_OFF:  if (cmd_rise) state_d = CH_ON;
      CH_ON:   if (!cmd_on) state_d = CH_OFF;
               else if (trip) state_d = CH_SOFT;
      CH_SOFT: if (ssd_last) state_d = CH_OFF;
      default: state_d = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == CH_SOFT) && ssd_last;
    end
  end

  assign src_en     = (state_q == CH_ON);
  assign boost_en   = src_en && boost_live;
  assign sink_en    = (state_q == CH_OFF);
  assign ssd_en     = (state_q == CH_SOFT);
  assign ssd_busy_n = !ssd_en;
  assign ssd_done   = done_q;

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({src_en, sink_en, ssd_en}) == 1); // R7
  AST_BOOST_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en |-> src_en); // R3
  AST_TRIP_UNBLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CH_SOFT) && ($past(state_q) == CH_ON)) |-> $past(blank_idle)); // R4
  AST_OFF_NO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_OFF) |=> (state_q != CH_SOFT)); // R6
  AST_SOFT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CH_SOFT) && !ssd_last) |=> (state_q == CH_SOFT)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_done |=> !ssd_done); // R8
  AST_DONE_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_done |-> (sink_en && $past(ssd_en))); // R8
endmodule

// File: tb/dsb_sequencer_tb.sv
module dsb_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 12;
  localparam int FILT  = 5;
  localparam int SSD   = 20;
  localparam int BOOST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 1'b0;
  logic desat_in = 1'b0;
  logic src_en, boost_en, sink_en, ssd_en, ssd_busy_n, ssd_done;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsb_sequencer #(.BLANK_CYC(BLANK), .FILT_CYC(FILT), .SSD_CYC(SSD), .BOOST_CYC(BOOST)) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_on (cmd_on), .desat_in (desat_in),
    .src_en (src_en), .boost_en (boost_en), .sink_en (sink_en),
    .ssd_en (ssd_en), .ssd_busy_n (ssd_busy_n), .ssd_done (ssd_done)
  );

  // Reference model built from the requirements: 0 off, 1 on, 2 soft shutdown
  int m_st, m_k, m_run, m_left;
  bit m_prev, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_k <= 0; m_run <= 0; m_left <= 0; m_prev <= 0; m_done <= 0;
    end else begin
      m_done <= 0;
      case (m_st)
        0: if (cmd_on && !m_prev) begin m_st <= 1; m_k <= 0; m_run <= 0; end
        1: if (!cmd_on) m_st <= 0;
           else begin
             m_k <= m_k + 1;
             if (m_k >= BLANK && desat_in) begin
               if (m_run + 1 == FILT) begin m_st <= 2; m_left <= SSD; m_run <= 0; end
               else m_run <= m_run + 1;
             end else m_run <= 0;
           end
        default: if (m_left == 1) begin m_st <= 0; m_done <= 1; end
                 else m_left <= m_left - 1;
      endcase
      m_prev <= cmd_on;
    end
  end

  function automatic bit exp_src();   return m_st == 1; endfunction
  function automatic bit exp_boost(); return (m_st == 1) && (m_k < BOOST); endfunction
  function automatic bit exp_sink();  return m_st == 0; endfunction
  function automatic bit exp_ssd();   return m_st == 2; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 src_en", src_en, exp_src());
      chk("R2 sink_en", sink_en, exp_sink());
      chk("R3 boost_en", boost_en, exp_boost());
      chk("R7 ssd_en", ssd_en, exp_ssd());
      chk("R7 ssd_busy_n", ssd_busy_n, !exp_ssd());
      chk("R8 ssd_done", ssd_done, m_done);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int burst;
    burst = 0;
    void'($urandom(32'd20240611));
    step(2);
    // R1: outputs during reset
    chk("R1 sink_en in reset", sink_en, 1);
    chk("R1 src_en in reset", src_en, 0);
    chk("R1 ssd_busy_n in reset", ssd_busy_n, 1);
    rst_n = 1'b1;
    step(1);
    chk("R1 ssd_en after reset", ssd_en, 0);
    chk("R1 ssd_done after reset", ssd_done, 0);
    cmp_en = 1'b1;
    step(3);

    // R6: desat while off
    desat_in = 1'b1;
    step(30);
    chk("R6 sink_en held with desat while off", sink_en, 1);
    chk("R6 no soft shutdown while off", ssd_en, 0);
    desat_in = 1'b0;
    step(2);

    // R4: desat held across the blanking window
    cmd_on = 1'b1; desat_in = 1'b1;
    step(1);
    chk("R2 on one cycle after command", src_en, 1);
    step(BLANK - 1);
    desat_in = 1'b0;
    step(3);
    chk("R4 blanked desat ignored, still on", src_en, 1);
    chk("R4 blanked desat ignored, no ssd", ssd_en, 0);

    // R5: run one short of the filter length
    desat_in = 1'b1;
    step(FILT - 1);
    desat_in = 1'b0;
    step(3);
    chk("R5 short run rejected", src_en, 1);
    // R5: full run qualifies
    desat_in = 1'b1;
    step(FILT);
    chk("R5 full run starts soft shutdown", ssd_en, 1);
    desat_in = 1'b0;
    cmd_on = 1'b0;
    step(3);
    chk("R9 soft shutdown continues after command drop", ssd_en, 1);
    step(SSD);
    chk("R9 back to off after soft shutdown", sink_en, 1);

    // R9: command held high through the end of soft shutdown
    cmd_on = 1'b1;
    step(BLANK + 2);
    desat_in = 1'b1;
    step(FILT);
    chk("R7 soft shutdown entered", ssd_busy_n, 0);
    desat_in = 1'b0;
    step(SSD + 5);
    chk("R9 stays off with command still high", src_en, 0);
    chk("R9 sink held with command still high", sink_en, 1);
    cmd_on = 1'b0;
    step(2);
    cmd_on = 1'b1;
    step(2);
    chk("R9 fresh edge turns channel on", src_en, 1);
    cmd_on = 1'b0;
    step(3);

    // Random mix of command toggles and desat bursts
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(39) == 0) cmd_on = ~cmd_on;
      if (burst == 0) begin
        desat_in = 1'b0;
        if ($urandom_range(9) == 0) burst = int'($urandom_range(8, 1));
      end else begin
        desat_in = 1'b1;
        burst--;
      end
    end
    cmd_on = 1'b0; desat_in = 1'b0;
    step(SSD + 4);
    chk("R1 idle off state at end", sink_en, 1);
    finish_run();
  end
endmodule